// File: doc/BRIEF.md
# Micro-TLB with Size-Ordered Main-TLB Search

This block is the fast front end of an address translator. A virtual address is compared against all eight micro-TLB entries in the same cycle. On a hit, the physical address comes back in that cycle with no stall. On a miss, the requester is held stalled while a sequencer searches a 32-set, 2-way main TLB. The main TLB sits in a single-port SRAM outside the block, so the sequencer reads it once per candidate page size. It skips any size that no main-TLB entry currently uses. When an entry matches, it is copied into the micro-TLB, and the held request is answered from there in the next cycle.

Translations enter through a fill port. For each fill the block picks the SRAM set from the page size and the way from a per-set round-robin pointer, then drives the SRAM write port. It also records the page size in a presence mask. A flush request clears the micro-TLB and the presence mask, resets the way pointers, and walks all 32 sets writing invalid entries.

Page size codes are 0 = 1 KB, 1 = 4 KB, 2 = 16 KB, 3 = 64 KB and 4 = 1 MB. A main-TLB entry word is 48 bits wide and is laid out as follows:

- bit 47: valid
- bits 46:44: size code
- bits 43:22: virtual page, which is address bits 31:10 with the bits below the page size cleared
- bits 21:0: physical page, in the same form

The SRAM returns its read data one cycle after the read, with way 0 in bits 47:0 and way 1 in bits 95:48.

Top module: `utlb_msearch`

## Requirements
- R1: When the sequencer is idle and a valid lookup hits the micro-TLB, `lk_hit` is 1 and `lk_stall` is 0 in the same cycle. `lk_paddr` is then the entry's physical page bits above the page offset, joined with the lookup address bits below it.
- R2: The micro-TLB holds 8 entries and each refill goes to the slot named by a round-robin pointer that starts at slot 0 after reset or flush. The ninth refill therefore evicts the first.
- R3: On a micro-TLB miss, the main TLB is probed in ascending size-code order, only for sizes present in the mask, with one SRAM read per probe and never two reads in consecutive cycles. The read set for size s is taken from the address bits just above that page's offset: bits 14:10, 16:12, 18:14, 20:16 or 24:20.
- R4: A main-TLB way matches only when it is valid, its size code equals the probed size, and its virtual page equals the masked lookup page. The same SRAM set can hold entries of different sizes.
- R5: A main-TLB hit on the k-th probe keeps `lk_stall` high for exactly 2k+2 cycles, and `lk_hit` is high in the cycle where the stall drops.
- R6: If all n present sizes miss, `lk_stall` stays high for 1+2n cycles and then `lk_tlb_miss` pulses for one cycle with `lk_stall` low. An empty mask gives a 1-cycle stall.
- R7: An accepted fill drives `sram_wr_en` in the same cycle with the size-derived set, a one-hot way mask taken from that set's round-robin pointer (way 0 first, alternating), and the entry word described above.
- R8: A fill sets the mask bit for its size, and a miss search issues no probe for an absent size. Only a flush clears the mask.
- R9: An accepted flush is followed by exactly 32 cycles of writes to sets 0 to 31 in order, with both ways enabled and all-zero data. During these cycles a valid lookup sees `lk_stall` high. Afterwards the micro-TLB is empty and all way pointers are back at way 0.
- R10: A fill presented in the cycle a flush is accepted, or during the flush walk, is dropped and leaves no trace in the SRAM or the mask.
- R11: While reset is asserted, `lk_hit`, `lk_stall`, `lk_tlb_miss`, `sram_rd_en` and `sram_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request, held until answered |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Translation delivered this cycle |
| lk_paddr | output | 32 | Translated physical address |
| lk_stall | output | 1 | Requester must hold |
| lk_tlb_miss | output | 1 | Main-TLB search found nothing |
| flush_req | input | 1 | Invalidate all translations |
| fill_valid | input | 1 | Write a new translation |
| fill_vpage | input | 22 | Virtual address bits 31:10 |
| fill_ppage | input | 22 | Physical address bits 31:10 |
| fill_size | input | 3 | Page size code 0..4 |
| sram_rd_en | output | 1 | Main-TLB SRAM read strobe |
| sram_rd_set | output | 5 | Set read |
| sram_rd_data | input | 96 | Both ways, one cycle after read |
| sram_wr_en | output | 1 | Main-TLB SRAM write strobe |
| sram_wr_set | output | 5 | Set written |
| sram_wr_ways | output | 2 | Way write enables |
| sram_wr_data | output | 48 | Entry word written |

## Verification
A wrong presence mask or probe pointer shows up at the ports within the next miss. The stall length shifts by two cycles for each wrongly probed or skipped size, and the order of `sram_rd_set` values is wrong at once. A bad micro-TLB round-robin pointer stays hidden until the ninth refill, when a page expected to survive instead costs a 4-cycle stall, or the reverse. A stale per-set way pointer is visible on `sram_wr_ways` at the very next fill to that set. A lost or partial flush appears as an early end of the 32-cycle write run, or as a lookup that hits when it should miss.

// File: rtl/utlb_ms_pkg.sv
package utlb_ms_pkg;
  localparam int VA_W   = 32;
  localparam int PG_MIN = 10;
  localparam int PN_W   = VA_W - PG_MIN;
  localparam int NSZ    = 5;
  localparam int SZ_W   = 3;
  localparam int UT_N   = 8;
  localparam int MT_SETS = 32;
  localparam int MT_WAYS = 2;
  localparam int IDX_W  = $clog2(MT_SETS);
  localparam int ENT_W  = 1 + SZ_W + 2 * PN_W;

  typedef struct packed {
    logic            vld;
    logic [SZ_W-1:0] sz;
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] ppn;
  } xent_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CMP, S_FILL, S_MISS, S_FLUSH
  } seq_st_e;

  // page offset width for a size code
  function automatic int sz_shift(input logic [SZ_W-1:0] s);
    return (s >= SZ_W'(4)) ? 20 : PG_MIN + 2 * int'(s);
  endfunction

  function automatic logic [PN_W-1:0] pn_mask(input logic [SZ_W-1:0] s);
    logic [PN_W-1:0] m;
    m = '1;
    return m << (sz_shift(s) - PG_MIN);
  endfunction

  function automatic logic [IDX_W-1:0] set_of(input logic [PN_W-1:0] vp,
                                              input logic [SZ_W-1:0] s);
    return IDX_W'(vp >> (sz_shift(s) - PG_MIN));
  endfunction

  function automatic logic ent_match(input xent_t e, input logic [PN_W-1:0] vp);
    return e.vld && ((vp & pn_mask(e.sz)) == e.vpn);
  endfunction

  function automatic logic [VA_W-1:0] xlate(input xent_t e, input logic [VA_W-1:0] va);
    logic [PN_W-1:0] m;
    m = pn_mask(e.sz);
    return {(e.ppn & m) | (va[VA_W-1:PG_MIN] & ~m), va[PG_MIN-1:0]};
  endfunction

  function automatic logic [SZ_W-1:0] low_sz(input logic [NSZ-1:0] m);
    logic [SZ_W-1:0] r;
    r = '0;
    for (int i = NSZ - 1; i >= 0; i--) if (m[i]) r = SZ_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
  import utlb_ms_pkg::*;
#(
  parameter int N = UT_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  xent_t           wr_ent,
  input  logic [VA_W-1:0] lk_va,
  output logic            hit,
  output xent_t           hit_ent
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  xent_t         ent_q [N];
  xent_t         ent_d [N];
  logic [PW-1:0] ptr_q, ptr_d;
  logic [N-1:0]  mv;
  logic          upd;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign mv[g] = ent_match(ent_q[g], lk_va[VA_W-1:PG_MIN]);
  end

  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && mv[i]) begin
        hit     = 1'b1;
        hit_ent = ent_q[i];
      end
    end
  end

  assign upd = clr | wr_en;

  always_comb begin
    ent_d = ent_q;
    ptr_d = ptr_q;
    if (clr) begin
      for (int i = 0; i < N; i++) ent_d[i].vld = 1'b0;
      ptr_d = '0;
    end else if (wr_en) begin
      ent_d[ptr_q] = wr_ent;
      ptr_d = (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ent_q[i] <= '0;
      ptr_q <= '0;
    end else if (upd) begin
      ent_q <= ent_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/mt_keeper.sv
module mt_keeper
  import utlb_ms_pkg::*;
#(
  parameter int SETS = MT_SETS,
  parameter int WAYS = MT_WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             flush_act,
  input  logic [IDX_W-1:0] flush_set,
  input  logic             fill_valid,
  input  logic [PN_W-1:0]  fill_vpage,
  input  logic [PN_W-1:0]  fill_ppage,
  input  logic [SZ_W-1:0]  fill_size,
  output logic [NSZ-1:0]   present,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_set,
  output logic [WAYS-1:0]  wr_ways,
  output xent_t            wr_data
);
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [NSZ-1:0]          pres_q, pres_d;
  logic [SETS-1:0][WW-1:0] rr_q, rr_d;
  logic                    fill_ok;
  logic [IDX_W-1:0]        fset;
  logic [WW-1:0]           fway;
  logic                    upd;

  assign fill_ok = fill_valid && !flush_act && !clr && (fill_size < SZ_W'(NSZ));
  assign fset    = set_of(fill_vpage, fill_size);
  assign fway    = rr_q[fset];
  assign present = pres_q;

  always_comb begin
    wr_en   = 1'b0;
    wr_set  = '0;
    wr_ways = '0;
    wr_data = '0;
    if (flush_act) begin
      wr_en   = 1'b1;
      wr_set  = flush_set;
      wr_ways = '1;
    end else if (fill_ok) begin
      wr_en       = 1'b1;
      wr_set      = fset;
      wr_ways     = WAYS'(1) << fway;
      wr_data.vld = 1'b1;
      wr_data.sz  = fill_size;
      wr_data.vpn = fill_vpage & pn_mask(fill_size);
      wr_data.ppn = fill_ppage & pn_mask(fill_size);
    end
  end

  assign upd = clr | fill_ok;

  always_comb begin
    pres_d = pres_q;
    rr_d   = rr_q;
    if (clr) begin
      pres_d = '0;
      rr_d   = '0;
    end else if (fill_ok) begin
      pres_d[fill_size] = 1'b1;
      rr_d[fset] = (fway == WW'(WAYS - 1)) ? '0 : fway + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      rr_q   <= '0;
    end else if (upd) begin
      pres_q <= pres_d;
      rr_q   <= rr_d;
    end
  end
endmodule

// File: rtl/ms_seq.sv
module ms_seq
  import utlb_ms_pkg::*;
#(
  parameter int SETS = MT_SETS,
  parameter int WAYS = MT_WAYS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic                  u_hit,
  input  logic [NSZ-1:0]        present,
  input  logic                  flush_req,
  input  logic [WAYS*ENT_W-1:0] rd_data,
  output logic                  idle,
  output logic                  rd_en,
  output logic [IDX_W-1:0]      rd_set,
  output logic                  refill_en,
  output xent_t                 refill_ent,
  output logic                  clr,
  output logic                  flush_act,
  output logic [IDX_W-1:0]      flush_set,
  output logic                  stall,
  output logic                  tlb_miss
);
  seq_st_e          st_q, st_d;
  logic [PN_W-1:0]  vp_q, vp_d;
  logic [NSZ-1:0]   pend_q, pend_d;
  logic [SZ_W-1:0]  cur_q, cur_d;
  xent_t            ent_q, ent_d;
  logic [IDX_W-1:0] fcnt_q, fcnt_d;
  xent_t            way_e [WAYS];
  logic [WAYS-1:0]  way_hit;
  logic             any_hit;
  xent_t            sel_e;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_e[w]   = xent_t'(rd_data[w*ENT_W +: ENT_W]);
    assign way_hit[w] = (way_e[w].sz == cur_q) && ent_match(way_e[w], vp_q);
  end

  always_comb begin
    any_hit = 1'b0;
    sel_e   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_hit && way_hit[w]) begin
        any_hit = 1'b1;
        sel_e   = way_e[w];
      end
    end
  end

  always_comb begin
    st_d      = st_q;
    vp_d      = vp_q;
    pend_d    = pend_q;
    cur_d     = cur_q;
    ent_d     = ent_q;
    fcnt_d    = fcnt_q;
    idle      = 1'b0;
    rd_en     = 1'b0;
    rd_set    = set_of(vp_q, cur_q);
    refill_en = 1'b0;
    clr       = 1'b0;
    flush_act = 1'b0;
    stall     = 1'b0;
    tlb_miss  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        idle = 1'b1;
        if (flush_req) begin
          clr    = 1'b1;
          fcnt_d = '0;
          st_d   = S_FLUSH;
        end else if (lk_valid && !u_hit) begin
          stall = 1'b1;
          vp_d  = lk_va[VA_W-1:PG_MIN];
          if (present == '0) begin
            st_d = S_MISS;
          end else begin
            cur_d  = low_sz(present);
            pend_d = present & ~(NSZ'(1) << low_sz(present));
            st_d   = S_RD;
          end
        end
      end
      S_RD: begin
        stall = 1'b1;
        rd_en = 1'b1;
        st_d  = S_CMP;
      end
      S_CMP: begin
        stall = 1'b1;
        if (any_hit) begin
          ent_d = sel_e;
          st_d  = S_FILL;
        end else if (pend_q != '0) begin
          cur_d  = low_sz(pend_q);
          pend_d = pend_q & ~(NSZ'(1) << low_sz(pend_q));
          st_d   = S_RD;
        end else begin
          st_d = S_MISS;
        end
      end
      S_FILL: begin
        stall     = 1'b1;
        refill_en = 1'b1;
        st_d      = S_IDLE;
      end
      S_MISS: begin
        tlb_miss = 1'b1;
        st_d     = S_IDLE;
      end
      S_FLUSH: begin
        flush_act = 1'b1;
        stall     = lk_valid;
        fcnt_d    = fcnt_q + 1'b1;
        if (fcnt_q == IDX_W'(SETS - 1)) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign refill_ent = ent_q;
  assign flush_set  = fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      vp_q   <= '0;
      pend_q <= '0;
      cur_q  <= '0;
      ent_q  <= '0;
      fcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      vp_q   <= vp_d;
      pend_q <= pend_d;
      cur_q  <= cur_d;
      ent_q  <= ent_d;
      fcnt_q <= fcnt_d;
    end
  end
endmodule

// File: rtl/utlb_msearch.sv
module utlb_msearch
  import utlb_ms_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  output logic                     lk_hit,
  output logic [VA_W-1:0]          lk_paddr,
  output logic                     lk_stall,
  output logic                     lk_tlb_miss,
  input  logic                     flush_req,
  input  logic                     fill_valid,
  input  logic [PN_W-1:0]          fill_vpage,
  input  logic [PN_W-1:0]          fill_ppage,
  input  logic [SZ_W-1:0]          fill_size,
  output logic                     sram_rd_en,
  output logic [IDX_W-1:0]         sram_rd_set,
  input  logic [MT_WAYS*ENT_W-1:0] sram_rd_data,
  output logic                     sram_wr_en,
  output logic [IDX_W-1:0]         sram_wr_set,
  output logic [MT_WAYS-1:0]       sram_wr_ways,
  output logic [ENT_W-1:0]         sram_wr_data
);
  logic [1:0]       rs_q;
  logic             rst_i;
  logic             u_hit, idle, refill_en, clr, flush_act, stall_w;
  logic             miss_w, hit_raw;
  xent_t            u_ent, refill_ent, wr_ent;
  logic [NSZ-1:0]   pres_w;
  logic [IDX_W-1:0] flush_set;
  logic             rd_en_w, wr_en_w;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  utlb_cam #(.N(UT_N)) u_cam (
    .clk(clk), .rst_n(rst_i), .clr(clr), .wr_en(refill_en), .wr_ent(refill_ent),
    .lk_va(lk_vaddr), .hit(u_hit), .hit_ent(u_ent)
  );

  ms_seq #(.SETS(MT_SETS), .WAYS(MT_WAYS)) u_seq (
    .clk(clk), .rst_n(rst_i), .lk_valid(lk_valid), .lk_va(lk_vaddr), .u_hit(u_hit),
    .present(pres_w), .flush_req(flush_req), .rd_data(sram_rd_data), .idle(idle),
    .rd_en(rd_en_w), .rd_set(sram_rd_set), .refill_en(refill_en), .refill_ent(refill_ent),
    .clr(clr), .flush_act(flush_act), .flush_set(flush_set), .stall(stall_w),
    .tlb_miss(miss_w)
  );

  mt_keeper #(.SETS(MT_SETS), .WAYS(MT_WAYS)) u_keep (
    .clk(clk), .rst_n(rst_i), .clr(clr), .flush_act(flush_act), .flush_set(flush_set),
    .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_ppage(fill_ppage),
    .fill_size(fill_size), .present(pres_w), .wr_en(wr_en_w), .wr_set(sram_wr_set),
    .wr_ways(sram_wr_ways), .wr_data(wr_ent)
  );

  assign hit_raw      = idle && lk_valid && u_hit;
  assign lk_hit       = hit_raw && rst_i;
  assign lk_paddr     = hit_raw ? xlate(u_ent, lk_vaddr) : '0;
  assign lk_stall     = stall_w && rst_i;
  assign lk_tlb_miss  = miss_w && rst_i;
  assign sram_rd_en   = rd_en_w && rst_i;
  assign sram_wr_en   = wr_en_w && rst_i;
  assign sram_wr_data = wr_ent;
endmodule

// File: rtl/utlb_msearch_chk.sv
module utlb_msearch_chk
  import utlb_ms_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_hit,
  input logic                 lk_stall,
  input logic                 lk_tlb_miss,
  input logic                 sram_rd_en,
  input logic                 sram_wr_en,
  input logic [IDX_W-1:0]     sram_wr_set,
  input logic [MT_WAYS-1:0]   sram_wr_ways,
  input logic [SZ_W-1:0]      fill_size,
  input logic [NSZ-1:0]       pres
);
  p_hit_nostall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_stall);

  p_rd_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_rd_en |=> !sram_rd_en);

  p_rd_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_rd_en |-> lk_stall);

  p_miss_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_tlb_miss |-> (!lk_stall && !lk_hit));

  p_miss_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_tlb_miss |=> !lk_tlb_miss);

  p_way_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> ($countones(sram_wr_ways) == 1 || (&sram_wr_ways)));

  p_pres_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_wr_en && $countones(sram_wr_ways) == 1) |=> pres[$past(fill_size)]);

  p_flush_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_wr_en && (&sram_wr_ways) && sram_wr_set != '0)
      |-> (sram_wr_set == $past(sram_wr_set) + 1'b1));
endmodule

bind utlb_msearch utlb_msearch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_stall(lk_stall),
  .lk_tlb_miss(lk_tlb_miss), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en),
  .sram_wr_set(sram_wr_set), .sram_wr_ways(sram_wr_ways), .fill_size(fill_size),
  .pres(pres_w)
);

// File: tb/utlb_msearch_tb_top.sv
module utlb_msearch_tb_top;
  logic        clk, rst_n;
  logic        lk_valid, lk_hit, lk_stall, lk_tlb_miss;
  logic [31:0] lk_vaddr, lk_paddr;
  logic        flush_req, fill_valid;
  logic [21:0] fill_vpage, fill_ppage;
  logic [2:0]  fill_size;
  logic        sram_rd_en, sram_wr_en;
  logic [4:0]  sram_rd_set, sram_wr_set;
  logic [95:0] sram_rd_data;
  logic [1:0]  sram_wr_ways;
  logic [47:0] sram_wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [4:0] rd_log [8];
  int rd_cnt;

  logic [47:0] mem [32][2];

  utlb_msearch dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_stall(lk_stall),
    .lk_tlb_miss(lk_tlb_miss), .flush_req(flush_req), .fill_valid(fill_valid),
    .fill_vpage(fill_vpage), .fill_ppage(fill_ppage), .fill_size(fill_size),
    .sram_rd_en(sram_rd_en), .sram_rd_set(sram_rd_set), .sram_rd_data(sram_rd_data),
    .sram_wr_en(sram_wr_en), .sram_wr_set(sram_wr_set), .sram_wr_ways(sram_wr_ways),
    .sram_wr_data(sram_wr_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // main-TLB SRAM model: registered read, per-way write
  initial begin
    for (int s = 0; s < 32; s++) begin
      mem[s][0] = '0;
      mem[s][1] = '0;
    end
    sram_rd_data = '0;
  end
  always @(posedge clk) begin
    if (sram_wr_en) begin
      if (sram_wr_ways[0]) mem[sram_wr_set][0] <= sram_wr_data;
      if (sram_wr_ways[1]) mem[sram_wr_set][1] <= sram_wr_data;
    end
    if (sram_rd_en) sram_rd_data <= {mem[sram_rd_set][1], mem[sram_rd_set][0]};
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [2:0] sz,
                      input logic [1:0] exp_ways, input string req);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_vpage = va[31:10];
    fill_ppage = pa[31:10];
    fill_size  = sz;
    #1;
    if (exp_ways != 2'b00) chk({req, " fill way"}, 64'(sram_wr_ways), 64'(exp_ways));
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input bit exp_miss, input logic [31:0] exp_pa,
                      input int exp_st, input string req);
    int n;
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    rd_cnt   = 0;
    #1;
    n = 0;
    while (lk_stall && n < 60) begin
      if (sram_rd_en && rd_cnt < 8) begin rd_log[rd_cnt] = sram_rd_set; rd_cnt++; end
      n++;
      @(negedge clk);
      #1;
    end
    chk({req, " stall cycles"}, 64'(n), 64'(exp_st));
    chk({req, " miss flag"}, 64'(lk_tlb_miss), 64'(exp_miss));
    chk({req, " hit flag"}, 64'(lk_hit), 64'(!exp_miss));
    if (!exp_miss) chk({req, " paddr"}, 64'(lk_paddr), 64'(exp_pa));
    lk_valid = 1'b0;
  endtask

  // va, expect main miss, expected paddr, expected stall cycles
  localparam logic [72:0] VEC [7] = '{
    {32'h0000_3ABC, 1'b0, 32'h1234_5ABC, 8'd6},
    {32'h0000_3004, 1'b0, 32'h1234_5004, 8'd0},
    {32'h403A_BCDE, 1'b0, 32'h900A_BCDE, 8'd8},
    {32'h0000_0555, 1'b0, 32'h0070_0D55, 8'd4},
    {32'h7000_0000, 1'b1, 32'h0000_0000, 8'd7},
    {32'h403F_FFFF, 1'b0, 32'h900F_FFFF, 8'd0},
    {32'h0002_3000, 1'b1, 32'h0000_0000, 8'd7}
  };

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; flush_req = 1'b0;
    fill_valid = 1'b0; fill_vpage = '0; fill_ppage = '0; fill_size = '0;
    repeat (3) @(negedge clk);
    // R11: quiet outputs in reset
    chk("R11 hit", 64'(lk_hit), 64'd0);
    chk("R11 stall", 64'(lk_stall), 64'd0);
    chk("R11 miss", 64'(lk_tlb_miss), 64'd0);
    chk("R11 rd_en", 64'(sram_rd_en), 64'd0);
    chk("R11 wr_en", 64'(sram_wr_en), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: empty mask, one stall cycle then miss
    look(32'h0000_3ABC, 1'b1, 32'h0, 1, "R6 empty mask");

    // R7: fills, set / way / data
    @(negedge clk);
    fill_valid = 1'b1; fill_vpage = 22'h00000C; fill_ppage = 22'h048D14; fill_size = 3'd1;
    #1;
    chk("R7 fill set", 64'(sram_wr_set), 64'd3);
    chk("R7 fill ways", 64'(sram_wr_ways), 64'b01);
    chk("R7 fill data", 64'(sram_wr_data), 64'({1'b1, 3'd1, 22'h00000C, 22'h048D14}));
    @(negedge clk);
    fill_valid = 1'b0;
    fill(32'h4030_0000, 32'h9000_0000, 3'd4, 2'b10, "R7 same set second way");
    fill(32'h0000_0400, 32'h0070_0C00, 3'd0, 2'b01, "R7 1KB");

    // R1 R3 R4 R5 R6 R8 table walk
    for (int i = 0; i < 7; i++) begin
      look(VEC[i][72:41], VEC[i][40], VEC[i][39:8], int'(VEC[i][7:0]),
           $sformatf("R5 R1 R4 vec%0d", i));
      if (i == 2) begin
        // R3: ascending size order, absent sizes skipped
        chk("R3 probe count", 64'(rd_cnt), 64'd3);
        chk("R3 probe0 set", 64'(rd_log[0]), 64'h0F);
        chk("R3 probe1 set", 64'(rd_log[1]), 64'h0B);
        chk("R3 probe2 set", 64'(rd_log[2]), 64'h03);
      end
    end

    // R9 R10: flush walk, fills dropped
    begin
      int n;
      bit stall_ok;
      @(negedge clk);
      flush_req = 1'b1;
      fill_valid = 1'b1; fill_vpage = 22'h00000C; fill_ppage = 22'h048D14; fill_size = 3'd1;
      #1;
      chk("R10 fill dropped at flush accept", 64'(sram_wr_en), 64'd0);
      @(negedge clk);
      flush_req = 1'b0;
      lk_valid = 1'b1; lk_vaddr = 32'h0000_3ABC;
      #1;
      chk("R9 first flush set", 64'(sram_wr_set), 64'd0);
      n = 0;
      stall_ok = 1;
      while (sram_wr_en && sram_wr_ways == 2'b11 && sram_wr_data == '0 && n < 100) begin
        if (!lk_stall) stall_ok = 0;
        n++;
        if (n == 3) fill_valid = 1'b0;
        @(negedge clk);
        #1;
      end
      lk_valid = 1'b0;
      chk("R9 flush length", 64'(n), 64'd32);
      chk("R9 stall during flush", 64'(stall_ok), 64'd1);
    end
    // R8 R9 R10: nothing left after flush
    look(32'h0000_3ABC, 1'b1, 32'h0, 1, "R8 R10 after flush");

    // R2: micro-TLB round robin
    for (int i = 0; i < 9; i++)
      fill(32'h0010_0000 + 32'(i) * 32'h1000, 32'h2000_0000 + 32'(i) * 32'h1000, 3'd1,
           2'b01, "R9 way pointer reset");
    for (int i = 0; i < 9; i++)
      look(32'h0010_0123 + 32'(i) * 32'h1000, 1'b0, 32'h2000_0123 + 32'(i) * 32'h1000, 4,
           "R2 refill");
    look(32'h0010_1123, 1'b0, 32'h2000_1123, 0, "R2 slot1 kept");
    look(32'h0010_0123, 1'b0, 32'h2000_0123, 4, "R2 slot0 evicted");
    look(32'h0010_8123, 1'b0, 32'h2000_8123, 0, "R2 ninth kept");
    look(32'h0010_1123, 1'b0, 32'h2000_1123, 4, "R2 slot1 now evicted");

    // R7: per-set way round robin
    fill(32'h0040_5000, 32'h3100_0000, 3'd1, 2'b10, "R7 set5 A");
    fill(32'h0060_5000, 32'h3200_0000, 3'd1, 2'b01, "R7 set5 B");
    fill(32'h0080_5000, 32'h3000_5000, 3'd1, 2'b10, "R7 set5 C");
    look(32'h0040_5010, 1'b1, 32'h0, 3, "R7 A overwritten");
    look(32'h0080_5FFF, 1'b0, 32'h3000_5FFF, 4, "R7 C present");
    look(32'h0060_5ABC, 1'b0, 32'h3200_0ABC, 4, "R7 B present");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule